// File: doc/BRIEF.md
# Acknowledge-Driven Request Retry Controller

This block drives a transmit request line from a single system clock and reacts to an acknowledge signal that comes from an unrelated clock domain. Two flip-flops bring the raw acknowledge into the local clock domain. A third register keeps the previous synchronized sample, and a rising edge is recognized when that sample was low and the current synchronized value is high. The acknowledge line never clocks any register.

When an acknowledge edge is recognized, the controller drops the request and restarts a saturating back-off counter. The request comes back on its own once the counter reaches a programmed count. A debug output shows the recognized edge pulse.

The controller is a two-state machine. `ST_BACKOFF` holds the request low and `ST_ASSERT` holds it high. Transitions:
- `BACKOFF->ASSERT`: the counter equals the rearm count and no edge is seen.
- `ASSERT->BACKOFF`: an edge is seen.
- `BACKOFF->BACKOFF`: an edge is seen while already backing off. The counter restarts.

Top module: `req_retry_handshake`

## Requirements
- R1: While `rst_n` is low, `tx_req` and `ack_edge_dbg` are 0. The counter and all synchronizer registers are cleared. After reset is released, with `ack_raw` held low, `tx_req` rises on the third clock edge.
- R2: `ack_raw` is sampled on two successive clock edges before edge detection. Say `ack_raw` is first high at clock edge k after being low at edge k-1. Then `ack_edge_dbg` (1 = edge recognized) is high for exactly the one cycle between edges k+1 and k+2.
- R3: On the clock edge that ends a cycle with `ack_edge_dbg` high, `tx_req` goes to 0.
- R4: The counter clears to 0 on a clock edge where an edge is recognized. It increments by one on every other clock edge.
- R5: When the counter equals `REARM_COUNT` (default 2) and no edge is recognized, `tx_req` goes to 1 on that clock edge. With no further edges, the request is therefore low for exactly 3 cycles after being withdrawn.
- R6: The counter is `CNT_W` bits wide (default 8). It saturates at its maximum value instead of wrapping, so `tx_req` stays high through any quiet period longer than 256 cycles.
- R7: If an edge is recognized in the same cycle that the counter equals `REARM_COUNT`, the edge takes priority: `tx_req` stays 0 and the counter restarts from 0.
- R8: `ack_raw` levels and falling transitions have no effect on `tx_req`. Once high, `tx_req` stays high until an edge is recognized.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ack_raw | input | 1 | Acknowledge from another clock domain |
| tx_req | output | 1 | Transmit request, 1 = requesting |
| ack_edge_dbg | output | 1 | One-cycle pulse on each recognized acknowledge rising edge |

## Verification
Two events can land in the same cycle: a recognized acknowledge edge, and the counter reaching its rearm value. A directed sequence provokes this collision. It pulses `ack_raw` as 1,0,0,1 on four successive clock edges, so the second synchronized edge arrives exactly when the back-off count hits 2. The bench then confirms that the request stays low and that it rises only three cycles later. Seeded random toggling of `ack_raw` also produces the collision, along with many other edge spacings. Each cycle is compared against a bench reference model built from the requirements.

// File: rtl/rrh_pkg.sv
package rrh_pkg;
    typedef enum logic {
        ST_BACKOFF = 1'b0,
        ST_ASSERT  = 1'b1
    } rrh_state_e;
endpackage

// File: rtl/rrh_ack_sync.sv
module rrh_ack_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[SYNC_STAGES-1];
    end

    assign level_o = chain_q[SYNC_STAGES-1];
    assign rise_o  = chain_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/rrh_backoff_cnt.sv
module rrh_backoff_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (restart_i)        cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/req_retry_handshake.sv
module req_retry_handshake #(
    parameter int CNT_W       = 8,
    parameter int REARM_COUNT = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_raw,
    output logic tx_req,
    output logic ack_edge_dbg
);
    import rrh_pkg::*;

    localparam logic [CNT_W-1:0] REARM_VAL = CNT_W'(REARM_COUNT);

    logic             ack_lvl;
    logic             ack_rise;
    logic [CNT_W-1:0] cnt_val;
    rrh_state_e       state_q;
    rrh_state_e       state_d;

    rrh_ack_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ack_raw),
        .level_o (ack_lvl),
        .rise_o  (ack_rise)
    );

    rrh_backoff_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ack_rise),
        .count_o   (cnt_val)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BACKOFF: begin
                if (ack_rise)                  state_d = ST_BACKOFF;
                else if (cnt_val == REARM_VAL) state_d = ST_ASSERT;
            end
            ST_ASSERT: begin
                if (ack_rise) state_d = ST_BACKOFF;
            end
            default: state_d = ST_BACKOFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BACKOFF;
        else        state_q <= state_d;
    end

    always_comb begin
        tx_req       = (state_q == ST_ASSERT);
        ack_edge_dbg = ack_rise;
    end

    logic unused_lvl;
    assign unused_lvl = ack_lvl;
endmodule

// File: rtl/rrh_chk.sv
module rrh_chk #(
    parameter int CNT_W       = 8,
    parameter int REARM_COUNT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_req,
    input logic             ack_edge_dbg,
    input logic [CNT_W-1:0] cnt_val
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R2
    edge_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_edge_dbg |=> !ack_edge_dbg);

    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_edge_dbg |=> !tx_req);

    // R4
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_edge_dbg |=> (cnt_val == '0));

    // R5
    req_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_edge_dbg && !tx_req && cnt_val == CNT_W'(REARM_COUNT)) |=> tx_req);

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_edge_dbg && cnt_val == CNT_MAX) |=> (cnt_val == CNT_MAX));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !ack_edge_dbg) |=> tx_req);
endmodule

bind req_retry_handshake rrh_chk #(
    .CNT_W       (CNT_W),
    .REARM_COUNT (REARM_COUNT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_req       (tx_req),
    .ack_edge_dbg (ack_edge_dbg),
    .cnt_val      (cnt_val)
);

// File: tb/req_retry_handshake_tb.sv
module req_retry_handshake_tb;
    localparam int CNT_W = 8;
    localparam int REARM = 2;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack_raw = 1'b0;
    logic tx_req;
    logic ack_edge_dbg;

    int n_checks = 0;
    int n_fail = 0;
    int collisions = 0;
    bit monitor_on = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    req_retry_handshake #(.CNT_W(CNT_W), .REARM_COUNT(REARM), .SYNC_STAGES(2)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack_raw      (ack_raw),
        .tx_req       (tx_req),
        .ack_edge_dbg (ack_edge_dbg)
    );

    // reference model from the requirements
    logic m_s1, m_s2, m_prev, m_req;
    int   m_cnt;

    function automatic bit f_edge(logic s2, logic prev);
        return s2 && !prev;
    endfunction

    function automatic int f_next_cnt(int c, bit e);
        if (e) return 0;
        return (c == MAXC) ? c : c + 1;
    endfunction

    function automatic logic f_next_req(logic r, int c, bit e);
        if (e) return 1'b0;
        if (c == REARM) return 1'b1;
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_cnt <= 0; m_req <= 0;
        end else begin
            if (f_edge(m_s2, m_prev) && m_cnt == REARM && !m_req) collisions <= collisions + 1;
            m_req  <= f_next_req(m_req, m_cnt, f_edge(m_s2, m_prev));
            m_cnt  <= f_next_cnt(m_cnt, f_edge(m_s2, m_prev));
            m_s1   <= ack_raw;
            m_s2   <= m_s1;
            m_prev <= m_s2;
        end
    end

    task automatic check(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (monitor_on && !finished) begin
            check(tx_req, m_req, "R3 R4 R5 R6 R7 R8 tx_req vs model");
            check(ack_edge_dbg, f_edge(m_s2, m_prev), "R2 ack_edge_dbg vs model");
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        cycles(150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        // R1 reset state
        cycles(3);
        check(tx_req, 1'b0, "R1 tx_req in reset");
        check(ack_edge_dbg, 1'b0, "R1 ack_edge_dbg in reset");
        rst_n = 1'b1;
        monitor_on = 1'b1;
        // R1 rises on the third clock edge after release
        cycles(2);
        check(tx_req, 1'b0, "R1 tx_req before third edge");
        cycles(1);
        check(tx_req, 1'b1, "R1 tx_req after third edge");

        // R6 R8 long quiet window past counter range
        cycles(300);
        check(tx_req, 1'b1, "R6 tx_req after long quiet");

        // R2 R3 R5 single acknowledge edge, latency
        ack_raw = 1'b1;           // sampled at edge k
        cycles(1);                // after k
        check(ack_edge_dbg, 1'b0, "R2 no pulse after one sample");
        cycles(1);                // after k+1
        check(ack_edge_dbg, 1'b1, "R2 pulse after second sample");
        check(tx_req, 1'b1, "R3 req still high during pulse");
        cycles(1);                // after k+2
        check(ack_edge_dbg, 1'b0, "R2 pulse lasts one cycle");
        check(tx_req, 1'b0, "R3 req withdrawn");
        cycles(2);
        check(tx_req, 1'b0, "R5 req low for three cycles");
        cycles(1);
        check(tx_req, 1'b1, "R5 req reasserted");

        // R8 falling ack and level high do nothing
        cycles(5);
        ack_raw = 1'b0;
        cycles(6);
        check(tx_req, 1'b1, "R8 falling ack ignored");
        check(ack_edge_dbg, 1'b0, "R8 no pulse on fall");

        // R7 collision: ack 1,0,0,1 on successive edges
        ack_raw = 1'b1;           // cycle A
        cycles(1); ack_raw = 1'b0;
        cycles(1); ack_raw = 1'b0;
        cycles(1); ack_raw = 1'b1;
        cycles(2);                // A+5
        check(ack_edge_dbg, 1'b1, "R7 second pulse at rearm count");
        check(tx_req, 1'b0, "R7 req low at collision");
        cycles(1);
        check(tx_req, 1'b0, "R7 edge wins over rearm");
        cycles(2);
        check(tx_req, 1'b0, "R7 counter restarted");
        cycles(1);
        check(tx_req, 1'b1, "R7 req back after restart");

        // random phase, compared against model every cycle
        ack_raw = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (($urandom % 4) == 0) ack_raw = ~ack_raw;
            if (($urandom % 200) == 0) begin
                ack_raw = 1'b0;
                cycles(260);
            end
        end
        n_checks++;
        if (collisions == 0) begin
            n_fail++;
            $display("FAIL R7 collision count: actual 0 expected >0");
        end

        cycles(4);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule